// File: doc/BRIEF.md
# Instruction Fetch Address Range Watcher

This block observes the stream of instruction fetch addresses leaving the processor and compares each valid fetch against a pair of programmable bounds. A mode bit selects whether a fetch counts as a hit when its address lies inside the closed interval between the bounds, or when it lies strictly outside that interval. Every hit produces a one-cycle event pulse. The pulse is meant to feed the counting input of a general event timer, so that an interrupt is raised after a chosen number of hits.

Software programs the block through a small register port. There is one control word holding an enable bit and the inside/outside select, plus one register for each bound. A write takes effect for fetches in the following cycle. A fetch in the same cycle as the write is judged with the old settings.

The event logic is a three-state machine. OFF is the reset state and is held while the enable bit is 0. ARMED means matching is enabled and no event is being driven. FIRE drives the event output high for that cycle. Transitions: OFF goes to FIRE on a matching fetch, to ARMED when enabled without a match, and otherwise stays in OFF. ARMED goes to OFF on disable, to FIRE on a match, and otherwise stays in ARMED. FIRE goes to OFF on disable, stays in FIRE on a further match, and otherwise returns to ARMED.

Top module: `fetch_range_watch`

## Requirements
- R1: While reset is asserted and in the cycle after it, the control word reads 0 and the event output is 0.
- R2: Register byte offsets: 0 is control (bit 0 enable, bit 1 outside select, all other bits read 0), 4 is the low bound, and 8 is the high bound. Bounds read back exactly as written. Writes to any other offset change nothing, and reads of any other offset return 0.
- R3: While the enable bit is 0, no event is produced, whatever the fetch address.
- R4: With the outside select at 0, a fetch hits when low <= address <= high. Both bounds are inclusive.
- R5: With the outside select at 1, a fetch hits when address < low or address > high. An address equal to either bound does not hit.
- R6: An address presented while fetch_valid is 0 never produces an event.
- R7: A hit fetch in cycle n drives evt high in cycle n+1 only. Back-to-back hit fetches give one high cycle per fetch.
- R8: When low > high, inside mode never hits and outside mode hits every valid fetch.
- R9: Bounds and addresses are compared as unsigned numbers.
- R10: A register write affects fetches from the next cycle on. A fetch in the same cycle as the write uses the previous settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_addr | input | AW (32) | Instruction fetch address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | OW (4) | Register byte offset |
| reg_wdata | input | AW (32) | Register write data |
| reg_rdata | output | AW (32) | Register read data for reg_addr, combinational |
| evt | output | 1 | One-cycle breakpoint event pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses and a 4-bit register offset. At this width, bounds that straddle 0x8000_0000 and addresses at the extremes 0 and 0xFFFF_FFFF show whether the comparison is unsigned. Directed cases set the bounds equal to the probe address and one away from it in both modes, and invert the interval. Random phases then place bounds in a narrow window so that hits, misses and boundary addresses all occur often, while control writes toggle the enable and the mode between fetches.

// File: rtl/frw_pkg.sv
package frw_pkg;
    // register byte offsets
    localparam int unsigned FRW_OFS_CTL = 0;
    localparam int unsigned FRW_OFS_LO  = 4;
    localparam int unsigned FRW_OFS_HI  = 8;

    typedef struct packed {
        logic outside;  // bit 1
        logic enable;   // bit 0
    } frw_ctl_t;

    localparam int unsigned FRW_CTL_W = $bits(frw_ctl_t);

    typedef enum logic [1:0] {
        FRW_OFF   = 2'd0,
        FRW_ARMED = 2'd1,
        FRW_FIRE  = 2'd2
    } frw_state_e;
endpackage

// File: rtl/frw_regs.sv
module frw_regs
    import frw_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [OW-1:0] reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output frw_ctl_t      ctl,
    output logic [AW-1:0] lo,
    output logic [AW-1:0] hi
);
    localparam logic [OW-1:0] A_CTL = OW'(FRW_OFS_CTL);
    localparam logic [OW-1:0] A_LO  = OW'(FRW_OFS_LO);
    localparam logic [OW-1:0] A_HI  = OW'(FRW_OFS_HI);

    logic sel_ctl, sel_lo, sel_hi;

    always_comb begin
        sel_ctl = (reg_addr == A_CTL);
        sel_lo  = (reg_addr == A_LO);
        sel_hi  = (reg_addr == A_HI);
    end

    // control word: cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (reg_wr && sel_ctl) begin
            ctl <= frw_ctl_t'(reg_wdata[FRW_CTL_W-1:0]);
        end
    end

    // bounds: no reset, contents undefined until written
    always_ff @(posedge clk) begin
        if (reg_wr && sel_lo) begin
            lo <= reg_wdata;
        end
        if (reg_wr && sel_hi) begin
            hi <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            sel_ctl: reg_rdata = AW'(ctl);
            sel_lo:  reg_rdata = lo;
            sel_hi:  reg_rdata = hi;
            default: reg_rdata = '0;
        endcase
    end

    // R1
    ctl_reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctl.enable == 1'b0 && ctl.outside == 1'b0));

    // R2
    ctl_write_only_at_ofs_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_addr == A_CTL) |=> $stable(ctl));
endmodule

// File: rtl/frw_cmp.sv
module frw_cmp
    import frw_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  frw_ctl_t      ctl,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    output logic          match
);
    logic in_range;
    logic out_range;

    // two separate comparator pairs, unsigned
    always_comb begin
        in_range  = (fetch_addr >= lo) && (fetch_addr <= hi);
        out_range = (fetch_addr <  lo) || (fetch_addr >  hi);
    end

    always_comb begin
        match = 1'b0;
        if (fetch_valid && ctl.enable) begin
            match = ctl.outside ? out_range : in_range;
        end
    end

    // R5
    range_partition_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> $onehot({in_range, out_range}));

    // R8
    inverted_bounds_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && lo > hi) |-> (!in_range && out_range));

    // R6
    idle_fetch_nomatch_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> !match);
endmodule

// File: rtl/frw_fsm.sv
module frw_fsm
    import frw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic match,
    output logic evt
);
    frw_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FRW_OFF: begin
                if (enable) state_nx = match ? FRW_FIRE : FRW_ARMED;
            end
            FRW_ARMED: begin
                if (!enable)    state_nx = FRW_OFF;
                else if (match) state_nx = FRW_FIRE;
            end
            FRW_FIRE: begin
                if (!enable)    state_nx = FRW_OFF;
                else if (match) state_nx = FRW_FIRE;
                else            state_nx = FRW_ARMED;
            end
            default: state_nx = FRW_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FRW_OFF;
        else     state <= state_nx;
    end

    always_comb begin
        evt = (state == FRW_FIRE);
    end

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !evt);

    // R7
    evt_follows_match_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> evt);

    // R7
    evt_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        !match |=> !evt);
endmodule

// File: rtl/fetch_range_watch.sv
module fetch_range_watch
    import frw_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned OW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          reg_wr,
    input  logic [OW-1:0] reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          evt
);
    frw_ctl_t      ctl;
    logic [AW-1:0] lo;
    logic [AW-1:0] hi;
    logic          match;

    frw_regs #(.AW(AW), .OW(OW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctl       (ctl),
        .lo        (lo),
        .hi        (hi)
    );

    frw_cmp #(.AW(AW)) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .lo          (lo),
        .hi          (hi),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .match       (match)
    );

    frw_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .enable (ctl.enable),
        .match  (match),
        .evt    (evt)
    );

    // R1
    reset_no_evt_chk: assert property (@(posedge clk)
        rst |=> !evt);
endmodule

// File: tb/tb_fetch_range_watch.sv
module tb_fetch_range_watch;
    localparam int unsigned AW = 32;
    localparam int unsigned OW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          fetch_valid;
    logic [AW-1:0] fetch_addr;
    logic          reg_wr;
    logic [OW-1:0] reg_addr;
    logic [AW-1:0] reg_wdata;
    logic [AW-1:0] reg_rdata;
    logic          evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // model state
    bit            m_en  = 0;
    bit            m_out = 0;
    logic [AW-1:0] m_lo  = '0;
    logic [AW-1:0] m_hi  = '0;

    always #2 clk = ~clk;  // 250 MHz

    fetch_range_watch #(.AW(AW), .OW(OW)) dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .evt         (evt)
    );

    function automatic bit exp_hit(bit vld, logic [AW-1:0] a);
        if (!vld || !m_en) return 1'b0;
        if (m_out) return (a < m_lo) || (a > m_hi);
        return (a >= m_lo) && (a <= m_hi);
    endfunction

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: optional fetch and optional write; evt checked next cycle
    task automatic cycle(string req, bit vld, logic [AW-1:0] a,
                         bit wr, logic [OW-1:0] ofs, logic [AW-1:0] d);
        bit e;
        e = exp_hit(vld, a);
        fetch_valid = vld;
        fetch_addr  = a;
        reg_wr      = wr;
        reg_addr    = ofs;
        reg_wdata   = d;
        @(negedge clk);
        if (wr) begin
            if (ofs == 4'd0) begin m_en = d[0]; m_out = d[1]; end
            else if (ofs == 4'd4) m_lo = d;
            else if (ofs == 4'd8) m_hi = d;
        end
        fetch_valid = 1'b0;
        reg_wr      = 1'b0;
        check(req, {31'd0, evt}, {31'd0, e});
    endtask

    task automatic wreg(logic [OW-1:0] ofs, logic [AW-1:0] d);
        cycle("R2", 1'b0, '0, 1'b1, ofs, d);
    endtask

    task automatic fetch(string req, logic [AW-1:0] a);
        cycle(req, 1'b1, a, 1'b0, '0, '0);
    endtask

    task automatic rd(string req, logic [OW-1:0] ofs, logic [AW-1:0] exp);
        reg_addr = ofs;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic setup(bit en, bit outside, logic [AW-1:0] lo, logic [AW-1:0] hi);
        wreg(4'd4, lo);
        wreg(4'd8, hi);
        wreg(4'd0, {30'd0, outside, en});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; fetch_valid = 0; fetch_addr = '0;
        reg_wr = 0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        // R1: control cleared, no event during reset
        rd("R1", 4'd0, '0);
        check("R1", {31'd0, evt}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        rd("R1", 4'd0, '0);
        check("R1", {31'd0, evt}, 32'd0);

        // R2 register map
        wreg(4'd0, 32'hFFFF_FFFC);
        rd("R2", 4'd0, 32'd0);
        wreg(4'd4, 32'h1234_5678);
        wreg(4'd8, 32'h9ABC_DEF0);
        rd("R2", 4'd4, 32'h1234_5678);
        rd("R2", 4'd8, 32'h9ABC_DEF0);
        wreg(4'd12, 32'hFFFF_FFFF);
        rd("R2", 4'd12, 32'd0);
        rd("R2", 4'd0, 32'd0);
        rd("R2", 4'd4, 32'h1234_5678);
        rd("R2", 4'd8, 32'h9ABC_DEF0);
        wreg(4'd0, 32'hFFFF_FFFF);
        rd("R2", 4'd0, 32'd3);

        // R3 disabled: in-range and out-of-range fetches are quiet
        setup(1'b0, 1'b0, 32'h100, 32'h200);
        fetch("R3", 32'h150);
        fetch("R3", 32'h100);
        wreg(4'd0, 32'd2);
        fetch("R3", 32'h50);

        // R4 inside inclusive
        setup(1'b1, 1'b0, 32'h100, 32'h200);
        fetch("R4", 32'h100);
        fetch("R4", 32'h200);
        fetch("R4", 32'h0FF);
        fetch("R4", 32'h201);
        fetch("R4", 32'h180);

        // R6 strobe low
        cycle("R6", 1'b0, 32'h180, 1'b0, '0, '0);

        // R7 back to back then idle
        fetch("R7", 32'h110);
        fetch("R7", 32'h120);
        fetch("R7", 32'h130);
        fetch("R7", 32'h300);
        cycle("R7", 1'b0, '0, 1'b0, '0, '0);

        // R5 outside strict
        wreg(4'd0, 32'd3);
        fetch("R5", 32'h100);
        fetch("R5", 32'h200);
        fetch("R5", 32'h0FF);
        fetch("R5", 32'h201);
        fetch("R5", 32'h180);

        // R8 inverted bounds
        setup(1'b1, 1'b0, 32'h500, 32'h400);
        fetch("R8", 32'h450);
        fetch("R8", 32'h500);
        fetch("R8", 32'h400);
        wreg(4'd0, 32'd3);
        fetch("R8", 32'h450);
        fetch("R8", 32'h0);
        fetch("R8", 32'hFFFF_FFFF);

        // R9 unsigned across the sign bit
        setup(1'b1, 1'b0, 32'h7FFF_FFF0, 32'h8000_0010);
        fetch("R9", 32'h8000_0000);
        fetch("R9", 32'hFFFF_FFFF);
        fetch("R9", 32'h0000_0000);
        wreg(4'd0, 32'd3);
        fetch("R9", 32'hFFFF_FFFF);
        fetch("R9", 32'h8000_0000);

        // R10 write in the same cycle as a hit fetch uses old settings
        setup(1'b1, 1'b0, 32'h100, 32'h200);
        cycle("R10", 1'b1, 32'h150, 1'b1, 4'd0, 32'd0);
        fetch("R10", 32'h150);
        cycle("R10", 1'b1, 32'h150, 1'b1, 4'd0, 32'd1);
        fetch("R10", 32'h150);
        cycle("R10", 1'b1, 32'h150, 1'b1, 4'd8, 32'h140);
        fetch("R10", 32'h150);

        // random phase: R4/R5 with enable and mode changes
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            if (r < 4) begin
                logic [AW-1:0] b = $urandom;
                wreg(4'd4, b);
                wreg(4'd8, b + $urandom_range(0, 30) - 4);
            end else if (r < 8) begin
                wreg(4'd0, {30'd0, 2'($urandom_range(0, 3))});
            end else begin
                logic [AW-1:0] a = m_lo + $urandom_range(0, 40) - 5;
                cycle(m_out ? "R5" : "R4", 1'($urandom_range(0, 5) != 0), a,
                      1'b0, '0, '0);
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule